// File: doc/BRIEF.md
# Control Register Access Permission and Update Unit

This block sits beside a hart's control/status register file. For each request it decides, in the same cycle, whether the access may go ahead. It also computes the word that the register file should store. The request carries:

- a 12-bit register address
- the current privilege level
- the virtualization, hypervisor-present and debug-access flags
- a two-bit operation code
- an operand
- the register's current contents

The block returns the current contents unchanged as the read result. It produces the merged update value, a write strobe, an illegal-access flag and a counter permission bit.

The permission logic combines three independent vetoes:

- **Read-only region with a write:** the address lies in the read-only region and the operation would modify the register.
- **Privilege too low:** the effective privilege is below the minimum encoded in the address. The debug flag waives this veto.
- **Counter not enabled:** the address selects a user counter whose enable bit has been cleared by the machine or supervisor enable word.

The block is purely combinational and contains no state machine: there are no states and no transitions. Register storage, per-register legalization and the reset of the enable words belong to the register file.

Top module: `csr_access_check`

## Requirements
- R1: An address with bits [11:10] = 2'b11 is read-only. An access to it whose write mask is nonzero raises `illegal`. A set or clear with a zero operand is still legal there.
- R2: The minimum privilege is address bits [9:8]. Privilege codes are U=0, S=1, M=3. An effective privilege below it raises `illegal` unless `dbg_access` is 1.
- R3: When `hyp_present` is 1, `priv_lvl` is S and `virt_on` is 0, the effective privilege is 2. Otherwise it equals `priv_lvl`.
- R4: `new_val` = (`old_val` AND NOT mask) OR (value AND mask).
- R5: The `op` codes give the following (value, mask) pairs:

  | `op` | Operation | value | mask |
  |------|-----------|-------|------|
  | 0 | read | 0 | 0 |
  | 1 | write | `operand` | all ones |
  | 2 | set | all ones | `operand` |
  | 3 | clear | 0 | `operand` |
- R6: `rd_val` always equals `old_val`.
- R7: `wr_en` is 1 only when the mask is nonzero.
- R8: An address is a counter when bits [11:8] = 4'hC and bits [6:5] = 2'b00. Its enable word is formed as follows:
  - it starts as all ones;
  - it is ANDed with `m_ctr_en` when the privilege is below M;
  - it is further ANDed with `s_ctr_en` when the privilege is below S (that is, U).
- R9: `ctr_allow` is the enable-word bit selected by address bits [4:0], and `illegal` is raised when it is 0. For any address that is not a counter, `ctr_allow` is 1. The debug flag does not waive this check.
- R10: `wr_en` is 0 whenever `illegal` is 1, and all outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 12 | Register address |
| priv_lvl | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt_on | input | 1 | Virtualization active |
| hyp_present | input | 1 | Hypervisor extension implemented |
| dbg_access | input | 1 | Access comes from the debugger |
| op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| operand | input | XLEN | Source operand |
| old_val | input | XLEN | Current register contents |
| m_ctr_en | input | 32 | Machine counter enable word |
| s_ctr_en | input | 32 | Supervisor counter enable word |
| rd_val | output | XLEN | Returned old value |
| new_val | output | XLEN | Merged update value |
| wr_en | output | 1 | Write strobe |
| illegal | output | 1 | Access refused |
| ctr_allow | output | 1 | Counter enable bit for this access |

## Verification
The bench targets a set or clear with a zero operand on a read-only address. A design that judges writability by the opcode rather than by the mask would flag this access as illegal. It also checks a host-mode supervisor reaching a level-2 address. A design missing the privilege bump rejects that access, and one that applies the bump while virtualized accepts it wrongly. Counter probes separate the machine-only and supervisor-plus-machine enable chains. They also use bit 31, where a wrong select width or a debug bypass of the counter check would show. Random vectors cover the merge arithmetic and the rule that the strobe is suppressed on every refused access.

// File: rtl/csr_chk_pkg.sv
package csr_chk_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;
    localparam int unsigned CTR_W   = 32;
    localparam int unsigned CTR_SEL = $clog2(CTR_W);
endpackage

// File: rtl/csr_rmw_merge.sv
module csr_rmw_merge #(
    parameter int unsigned XLEN = 32
) (
    input  csr_chk_pkg::csr_op_e op,
    input  logic [XLEN-1:0]      operand,
    input  logic [XLEN-1:0]      old_val,
    output logic [XLEN-1:0]      new_val,
    output logic                 mask_nz
);
    logic [XLEN-1:0] val, mask;

    always_comb begin
        unique case (op)
            csr_chk_pkg::OP_WRITE: begin val = operand;   mask = '1;      end
            csr_chk_pkg::OP_SET:   begin val = '1;        mask = operand; end
            csr_chk_pkg::OP_CLEAR: begin val = '0;        mask = operand; end
            default:               begin val = '0;        mask = '0;      end
        endcase
    end

    assign new_val = (old_val & ~mask) | (val & mask);
    assign mask_nz = |mask;
endmodule

// File: rtl/csr_priv_gate.sv
module csr_priv_gate #(
    parameter int unsigned AW = 12
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    priv_lvl,
    input  logic          virt_on,
    input  logic          hyp_present,
    input  logic          dbg_access,
    input  logic          mask_nz,
    output logic          deny
);
    logic       host_mode;
    logic [2:0] eff_priv;
    logic [1:0] min_priv;
    logic       ro_addr;

    assign host_mode = hyp_present && (priv_lvl == csr_chk_pkg::PRIV_S) && !virt_on;
    assign eff_priv  = {1'b0, priv_lvl} + {2'b00, host_mode};
    assign min_priv  = addr[AW-3:AW-4];
    assign ro_addr   = (addr[AW-1:AW-2] == 2'b11);
    assign deny      = (ro_addr && mask_nz) ||
                       (!dbg_access && (eff_priv < {1'b0, min_priv}));
endmodule

// File: rtl/csr_ctr_gate.sv
module csr_ctr_gate #(
    parameter int unsigned AW = 12
) (
    input  logic [AW-1:0]                  addr,
    input  logic [1:0]                     priv_lvl,
    input  logic [csr_chk_pkg::CTR_W-1:0]  m_ctr_en,
    input  logic [csr_chk_pkg::CTR_W-1:0]  s_ctr_en,
    output logic                           allow
);
    localparam int unsigned SW = csr_chk_pkg::CTR_SEL;
    logic                          is_ctr;
    logic [csr_chk_pkg::CTR_W-1:0] word;

    assign is_ctr = (addr[AW-1:AW-4] == 4'hC) && (addr[SW+1:SW] == 2'b00);

    always_comb begin
        word = '1;
        if (priv_lvl < csr_chk_pkg::PRIV_M) word = word & m_ctr_en;
        if (priv_lvl < csr_chk_pkg::PRIV_S) word = word & s_ctr_en;
    end

    assign allow = !is_ctr || word[addr[SW-1:0]];
endmodule

// File: rtl/csr_access_check.sv
module csr_access_check #(
    parameter int unsigned XLEN = 32
) (
    input  logic [11:0]     addr,
    input  logic [1:0]      priv_lvl,
    input  logic            virt_on,
    input  logic            hyp_present,
    input  logic            dbg_access,
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] operand,
    input  logic [XLEN-1:0] old_val,
    input  logic [31:0]     m_ctr_en,
    input  logic [31:0]     s_ctr_en,
    output logic [XLEN-1:0] rd_val,
    output logic [XLEN-1:0] new_val,
    output logic            wr_en,
    output logic            illegal,
    output logic            ctr_allow
);
    logic mask_nz, deny;

    csr_rmw_merge #(.XLEN(XLEN)) u_merge (
        .op(csr_chk_pkg::csr_op_e'(op)), .operand(operand), .old_val(old_val),
        .new_val(new_val), .mask_nz(mask_nz)
    );

    csr_priv_gate #(.AW(12)) u_priv (
        .addr(addr), .priv_lvl(priv_lvl), .virt_on(virt_on),
        .hyp_present(hyp_present), .dbg_access(dbg_access),
        .mask_nz(mask_nz), .deny(deny)
    );

    csr_ctr_gate #(.AW(12)) u_ctr (
        .addr(addr), .priv_lvl(priv_lvl), .m_ctr_en(m_ctr_en),
        .s_ctr_en(s_ctr_en), .allow(ctr_allow)
    );

    assign illegal = deny || !ctr_allow;
    assign wr_en   = mask_nz && !illegal;
    assign rd_val  = old_val;
endmodule

// File: rtl/csr_access_check_sva.sv
module csr_access_check_sva #(
    parameter int unsigned XLEN = 32
) (
    input logic [11:0]     addr,
    input logic [1:0]      priv_lvl,
    input logic            virt_on,
    input logic            hyp_present,
    input logic            dbg_access,
    input logic [1:0]      op,
    input logic [XLEN-1:0] operand,
    input logic [XLEN-1:0] old_val,
    input logic [XLEN-1:0] rd_val,
    input logic [XLEN-1:0] new_val,
    input logic            wr_en,
    input logic            illegal,
    input logic            ctr_allow
);
    logic       modifies;
    logic [2:0] eff;

    always_comb begin
        modifies = (op == 2'd1) || ((op != 2'd0) && (operand != '0));
        eff = (hyp_present && priv_lvl == 2'd1 && !virt_on) ? 3'd2 : {1'b0, priv_lvl};

        // R1
        if (addr[11:10] == 2'b11 && modifies)
            p_ro_modify_r1: assert (illegal);
        // R2
        if (!dbg_access && eff < {1'b0, addr[9:8]})
            p_low_priv_r2: assert (illegal);
        // R6
        p_old_return_r6: assert (rd_val == old_val);
        // R5
        if (op == 2'd0)
            p_read_quiet_r5: assert (!wr_en && new_val == old_val);
        // R9
        if (!ctr_allow)
            p_ctr_block_r9: assert (illegal);
        // R10
        if (illegal)
            p_no_strobe_r10: assert (!wr_en);
        // R7
        if (wr_en)
            p_strobe_mod_r7: assert (modifies);
    end
endmodule

bind csr_access_check csr_access_check_sva #(.XLEN(XLEN)) u_sva (
    .addr(addr), .priv_lvl(priv_lvl), .virt_on(virt_on),
    .hyp_present(hyp_present), .dbg_access(dbg_access), .op(op),
    .operand(operand), .old_val(old_val), .rd_val(rd_val),
    .new_val(new_val), .wr_en(wr_en), .illegal(illegal), .ctr_allow(ctr_allow)
);

// File: tb/sim_csr_access_check.sv
`timescale 1ns/1ps
module sim_csr_access_check;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [11:0]     addr;
    logic [1:0]      priv_lvl, op;
    logic            virt_on, hyp_present, dbg_access;
    logic [XLEN-1:0] operand, old_val;
    logic [31:0]     m_ctr_en, s_ctr_en;
    logic [XLEN-1:0] rd_val, new_val;
    logic            wr_en, illegal, ctr_allow;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    csr_access_check #(.XLEN(XLEN)) u0 (
        .addr(addr), .priv_lvl(priv_lvl), .virt_on(virt_on),
        .hyp_present(hyp_present), .dbg_access(dbg_access), .op(op),
        .operand(operand), .old_val(old_val), .m_ctr_en(m_ctr_en),
        .s_ctr_en(s_ctr_en), .rd_val(rd_val), .new_val(new_val),
        .wr_en(wr_en), .illegal(illegal), .ctr_allow(ctr_allow)
    );

    function automatic void model(output logic [XLEN-1:0] e_new,
                                  output logic e_wr, output logic e_ill,
                                  output logic e_ctr);
        logic [XLEN-1:0] v, m;
        logic [31:0] en;
        int eff;
        case (op)
            2'd0: begin v = 0;       m = 0;       end
            2'd1: begin v = operand; m = '1;      end
            2'd2: begin v = '1;      m = operand; end
            default: begin v = 0;    m = operand; end
        endcase
        eff = priv_lvl;
        if (hyp_present && priv_lvl == 1 && !virt_on) eff = 2;
        e_ill = 0;
        if (addr[11:10] == 3 && m != 0) e_ill = 1;
        if (!dbg_access && eff < int'(addr[9:8])) e_ill = 1;
        e_ctr = 1;
        if (addr[11:8] == 4'hC && addr[6:5] == 0) begin
            en = 32'hFFFF_FFFF;
            if (priv_lvl < 3) en = en & m_ctr_en;
            if (priv_lvl < 1) en = en & s_ctr_en;
            e_ctr = en[addr[4:0]];
        end
        if (!e_ctr) e_ill = 1;
        e_new = 0;
        for (int i = 0; i < XLEN; i++) e_new[i] = m[i] ? v[i] : old_val[i];
        e_wr = (m != 0) && !e_ill;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h addr=%h priv=%0d op=%0d",
                     tag, what, act, exp, addr, priv_lvl, op);
        end
    endtask

    task automatic apply(input string tag, input logic [11:0] a, input logic [1:0] p,
                         input logic v, input logic h, input logic d, input logic [1:0] o,
                         input logic [XLEN-1:0] opd, input logic [XLEN-1:0] old,
                         input logic [31:0] me, input logic [31:0] se);
        logic [XLEN-1:0] e_new;
        logic e_wr, e_ill, e_ctr;
        @(posedge clk);
        #1;
        addr = a; priv_lvl = p; virt_on = v; hyp_present = h; dbg_access = d;
        op = o; operand = opd; old_val = old; m_ctr_en = me; s_ctr_en = se;
        @(negedge clk);
        model(e_new, e_wr, e_ill, e_ctr);
        chk(tag, "illegal", {31'd0, illegal}, {31'd0, e_ill});
        chk(tag, "wr_en", {31'd0, wr_en}, {31'd0, e_wr});
        chk(tag, "ctr_allow", {31'd0, ctr_allow}, {31'd0, e_ctr});
        chk(tag, "new_val", new_val, e_new);
        chk("R6", "rd_val", rd_val, old);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        addr = 0; priv_lvl = 0; virt_on = 0; hyp_present = 0; dbg_access = 0;
        op = 0; operand = 0; old_val = 0; m_ctr_en = 0; s_ctr_en = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // idle state after reset: plain read of a user address
        apply("R7", 12'h000, 2'd0, 0, 0, 0, 2'd0, 0, 0, 0, 0);
        // R1 read-only region
        apply("R1", 12'hF11, 2'd3, 0, 0, 0, 2'd1, 32'h5, 32'h1234, 0, 0);
        apply("R1", 12'hF11, 2'd3, 0, 0, 0, 2'd2, 32'h0, 32'h1234, 0, 0);
        apply("R1", 12'hF11, 2'd3, 0, 0, 0, 2'd3, 32'h0, 32'h1234, 0, 0);
        apply("R1", 12'hF11, 2'd3, 0, 0, 0, 2'd0, 32'hFF, 32'h1234, 0, 0);
        // R2 privilege and debug waiver
        apply("R2", 12'h300, 2'd0, 0, 0, 0, 2'd0, 0, 32'hA5, 0, 0);
        apply("R2", 12'h300, 2'd1, 0, 0, 0, 2'd1, 32'h7, 32'hA5, 0, 0);
        apply("R2", 12'h300, 2'd0, 0, 0, 1, 2'd1, 32'h7, 32'hA5, 0, 0);
        apply("R2", 12'h140, 2'd1, 0, 0, 0, 2'd1, 32'h9, 32'h0, 0, 0);
        // R3 host-mode bump
        apply("R3", 12'h600, 2'd1, 0, 1, 0, 2'd1, 32'h3, 32'h0, 0, 0);
        apply("R3", 12'h600, 2'd1, 1, 1, 0, 2'd1, 32'h3, 32'h0, 0, 0);
        apply("R3", 12'h600, 2'd1, 0, 0, 0, 2'd1, 32'h3, 32'h0, 0, 0);
        apply("R3", 12'h300, 2'd1, 0, 1, 0, 2'd0, 32'h3, 32'h0, 0, 0);
        // R4 R5 merge per operation
        apply("R5", 12'h340, 2'd3, 0, 0, 0, 2'd1, 32'hDEAD_BEEF, 32'h1111_2222, 0, 0);
        apply("R5", 12'h340, 2'd3, 0, 0, 0, 2'd2, 32'h0F0F_0000, 32'h1111_2222, 0, 0);
        apply("R4", 12'h340, 2'd3, 0, 0, 0, 2'd3, 32'h0000_0F0F, 32'hFFFF_FFFF, 0, 0);
        apply("R7", 12'h340, 2'd3, 0, 0, 0, 2'd3, 32'h0, 32'hFFFF_FFFF, 0, 0);
        // R8 R9 counter chain
        apply("R8", 12'hC01, 2'd0, 0, 0, 0, 2'd0, 0, 0, 32'h2, 32'h0);
        apply("R8", 12'hC01, 2'd0, 0, 0, 0, 2'd0, 0, 0, 32'h2, 32'h2);
        apply("R8", 12'hC01, 2'd1, 0, 0, 0, 2'd0, 0, 0, 32'h2, 32'h0);
        apply("R8", 12'hC01, 2'd1, 0, 0, 0, 2'd0, 0, 0, 32'h0, 32'h2);
        apply("R8", 12'hC02, 2'd3, 0, 0, 0, 2'd0, 0, 0, 32'h0, 32'h0);
        apply("R9", 12'hC1F, 2'd0, 0, 0, 0, 2'd0, 0, 0, 32'h8000_0000, 32'h8000_0000);
        apply("R9", 12'hC1F, 2'd0, 0, 0, 1, 2'd0, 0, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        apply("R9", 12'hC81, 2'd0, 0, 0, 0, 2'd0, 0, 0, 32'h0, 32'h0);
        apply("R9", 12'hC21, 2'd0, 0, 0, 0, 2'd0, 0, 0, 32'h0, 32'h0);
        // R10 random sweep
        for (int n = 0; n < 400; n++) begin
            logic [11:0] ra;
            ra = 12'($urandom);
            if (n % 3 == 0) ra = {4'hC, 1'b0, 2'b00, 5'($urandom)};
            apply("R10", ra, 2'($urandom), 1'($urandom), 1'($urandom),
                  ((n % 7) == 0) ? 1'b1 : 1'b0, 2'($urandom),
                  ((n % 5) == 0) ? 32'h0 : 32'($urandom), 32'($urandom),
                  32'($urandom), 32'($urandom));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule